// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. Pages are 4 KiB. Each table entry is 4 bytes, so each table is 1024 entries long and fills one page. The walker accepts one translation request at a time. It cuts the address into a top 10-bit index, a middle 10-bit index and a 12-bit byte offset. It then reads the root-level entry and, if that entry is valid, the leaf-level entry. Each read goes through a read port that has only one read in flight. When the walk is done, the walker returns the leaf entry together with the physical address. If either level is invalid, it returns a fault instead.

The physical page of the root table comes from software through the `root_frame` input. The walker copies it when it accepts a request. Both table levels use one fixed entry layout:

| Bits | Meaning |
|------|---------|
| [31:12] | Frame number |
| [1] | Writable |
| [0] | Valid |
| [11:2] | Reserved. The walker returns these bits unchanged in the entry it reports. |

In a root entry, the frame field gives the physical page of the leaf table.

A client starts a walk with `req_valid`, while `req_ready` is high. The client then waits for `rsp_valid`. The response stays presented until the client takes it with `rsp_ready`. The block does not cache translations.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req` and `rsp_valid` are 0.
- R2: The first read of a walk is issued in the cycle after acceptance. Its address is {root_frame sampled at acceptance, VA[31:22], 2'b00}. Changing `root_frame` after acceptance has no effect on the walk.
- R3: A second read follows only when the root entry has bit 0 set. It is issued in the cycle after the root data returns. Its address is {root entry [31:12], VA[21:12], 2'b00}.
- R4: When the leaf entry is valid, the response has `rsp_fault`=0 and `rsp_pte` equal to the leaf entry, with every bit unchanged. `rsp_paddr` is {leaf entry [31:12], VA[11:0]}.
- R5: When the root entry has bit 0 clear, the walk ends with no second read. The response then has `rsp_fault`=1, `rsp_level`=0, `rsp_pte` equal to the root entry and `rsp_paddr`=0.
- R6: When the leaf entry has bit 0 clear, the response has `rsp_fault`=1, `rsp_level`=1, `rsp_pte` equal to the leaf entry and `rsp_paddr`=0.
- R7: Between acceptance and the response handshake, `req_ready` is 0, and a `req_valid` raised in that time is ignored. `req_ready` returns to 1 in the cycle after `rsp_valid` and `rsp_ready` are both high.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, all response fields hold their values. `rsp_vaddr` carries the translated virtual address.
- R9: While `mem_req` is 1 and `mem_rvalid` is 0, `mem_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_frame | input | 20 | Physical page number of the root table |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle; a request is accepted when this and `req_valid` are both high |
| mem_req | output | 1 | Table read pending |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid; completes the pending read |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_level | output | 1 | Level that faulted: 0 is the root, 1 is the leaf |
| rsp_pte | output | 32 | Last entry read |
| rsp_paddr | output | 32 | Physical address, or 0 on a fault |
| rsp_vaddr | output | 32 | Virtual address of this walk |

## Verification
The walker's state is small: a walk phase, the sampled root page, the request address and the middle frame. A wrong phase shows up at the ports within one read latency. It appears as a missing or extra second read, a fault reported at the wrong level, or `req_ready` rising before the handshake. A corrupted root copy or middle frame shows up as a wrong `mem_addr` on the very next read. A wrong offset path shows up only in `rsp_paddr`, so the checks compare every response field on every walk.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W   = 32,
  parameter int PTE_W  = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int VBIT   = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [VA_W-OFF_W-1:0]   root_frame,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_vaddr,
  output logic                    req_ready,
  output logic                    mem_req,
  output logic [VA_W-1:0]         mem_addr,
  input  logic                    mem_rvalid,
  input  logic [PTE_W-1:0]        mem_rdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic                    rsp_fault,
  output logic                    rsp_level,
  output logic [PTE_W-1:0]        rsp_pte,
  output logic [VA_W-1:0]         rsp_paddr,
  output logic [VA_W-1:0]         rsp_vaddr
);
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int ESZ_W   = OFF_W - IDX_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ROOT, ST_LEAF, ST_DONE} walk_t;

  walk_t              st;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] mid_q;
  logic [VA_W-1:0]    va_q;

  wire [IDX_W-1:0]   hi_idx = va_q[VA_W-1 -: IDX_W];
  wire [IDX_W-1:0]   lo_idx = va_q[OFF_W +: IDX_W];
  wire [FRAME_W-1:0] rd_frame = mem_rdata[PTE_W-1 -: FRAME_W];
  wire               rd_ok = mem_rdata[VBIT];

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_ROOT) || (st == ST_LEAF);
  assign mem_addr  = (st == ST_ROOT) ? {root_q, hi_idx, {ESZ_W{1'b0}}}
                                     : {mid_q, lo_idx, {ESZ_W{1'b0}}};
  assign rsp_valid = (st == ST_DONE);
  assign rsp_vaddr = va_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      root_q    <= '0;
      mid_q     <= '0;
      va_q      <= '0;
      rsp_fault <= 1'b0;
      rsp_level <= 1'b0;
      rsp_pte   <= '0;
      rsp_paddr <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          root_q <= root_frame;
          st     <= ST_ROOT;
        end
        ST_ROOT: if (mem_rvalid) begin
          if (!rd_ok) begin
            rsp_fault <= 1'b1;
            rsp_level <= 1'b0;
            rsp_pte   <= mem_rdata;
            rsp_paddr <= '0;
            st        <= ST_DONE;
          end else begin
            mid_q <= rd_frame;
            st    <= ST_LEAF;
          end
        end
        ST_LEAF: if (mem_rvalid) begin
          rsp_pte   <= mem_rdata;
          rsp_level <= 1'b1;
          rsp_fault <= !rd_ok;
          rsp_paddr <= rd_ok ? {rd_frame, va_q[OFF_W-1:0]} : '0;
          st        <= ST_DONE;
        end
        default: if (rsp_ready) st <= ST_IDLE;
      endcase
    end
  end

  AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_req &&
      mem_addr == {$past(root_frame), $past(req_vaddr[VA_W-1 -: IDX_W]), {ESZ_W{1'b0}}}); // R2
  AST_SECOND_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ROOT && mem_rvalid && rd_ok) |=> mem_req &&
      mem_addr == {$past(rd_frame), rsp_vaddr[OFF_W +: IDX_W], {ESZ_W{1'b0}}}); // R3
  AST_LEAF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LEAF && mem_rvalid && rd_ok) |=> rsp_valid && !rsp_fault &&
      rsp_paddr == {$past(rd_frame), rsp_vaddr[OFF_W-1:0]}); // R4
  AST_ROOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ROOT && mem_rvalid && !rd_ok) |=> rsp_valid && rsp_fault && !rsp_level && !mem_req); // R5
  AST_LEAF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LEAF && mem_rvalid && !rd_ok) |=> rsp_valid && rsp_fault && rsp_level); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_pte) && $stable(rsp_paddr) &&
      $stable(rsp_fault) && $stable(rsp_level) && $stable(rsp_vaddr)); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> mem_req && $stable(mem_addr)); // R9
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam logic [19:0] ROOT = 20'h00040;
  localparam logic [19:0] LEAF_BASE = 20'h10000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] root_frame = ROOT;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic        rsp_level;
  logic [31:0] rsp_pte;
  logic [31:0] rsp_paddr;
  logic [31:0] rsp_vaddr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int lat = 0;
  int wait_cnt = 0;
  int rd_n = 0;
  logic [31:0] rd_addr0, rd_addr1, first_addr;

  always #10 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_pte(rsp_pte), .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic root_ok(input logic [9:0] mi);
    return (mi % 7) != 3;
  endfunction
  function automatic logic leaf_ok(input logic [9:0] mi, input logic [9:0] si);
    return ((32'(mi) + 32'(si)) % 5) != 2;
  endfunction
  function automatic logic [31:0] root_entry(input logic [9:0] mi);
    return {LEAF_BASE + {10'd0, mi}, 10'd0, mi[0], root_ok(mi)};
  endfunction
  function automatic logic [31:0] leaf_entry(input logic [9:0] mi, input logic [9:0] si);
    return {({mi, si} ^ 20'hA5A5A), 7'd0, 3'b101, si[0], leaf_ok(mi, si)};
  endfunction

  function automatic logic [31:0] mem_model(input logic [31:0] a);
    if (a[31:12] == ROOT) return root_entry(a[11:2]);
    return leaf_entry(a[21:12], a[11:2]);
  endfunction

  always begin
    @(negedge clk);
    cycles++;
    mem_rvalid = 1'b0;
    if (mem_req) begin
      if (wait_cnt == 0) first_addr = mem_addr;
      if (wait_cnt >= lat) begin
        check(mem_addr == first_addr, "R9", mem_addr, first_addr);
        mem_rvalid = 1'b1;
        mem_rdata = mem_model(mem_addr);
        if (rd_n == 0) rd_addr0 = mem_addr; else rd_addr1 = mem_addr;
        rd_n++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      finish_run();
    end
  end

  task automatic walk(input logic [31:0] va, input int lat_i, input int mode);
    logic [9:0] mi = va[31:22];
    logic [9:0] si = va[21:12];
    logic [11:0] off = va[11:0];
    logic mv = root_ok(mi);
    logic lv = leaf_ok(mi, si);
    logic [31:0] e_pte, e_pa, s_pte, s_pa, s_va;
    logic s_f, s_l;
    int n;
    lat = lat_i;
    rd_n = 0;
    n = 0;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    req_valid = 1'b1;
    req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (mode == 1) begin
      check(req_ready == 1'b0, "R7", {31'd0, req_ready}, 32'd0);
      req_valid = 1'b1;
      req_vaddr = ~va;
      @(negedge clk);
      req_valid = 1'b0;
    end
    if (mode == 2) root_frame = 20'h00123;
    n = 0;
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    check(rsp_valid == 1'b1, "R4", {31'd0, rsp_valid}, 32'd1);
    check(rsp_vaddr == va, "R8", rsp_vaddr, va);
    check(rd_addr0 == {ROOT, mi, 2'b00}, "R2", rd_addr0, {ROOT, mi, 2'b00});
    if (!mv) begin
      check(rd_n == 1, "R5", rd_n, 1);
      check(rsp_fault && !rsp_level, "R5", {30'd0, rsp_fault, rsp_level}, 32'd2);
      e_pte = root_entry(mi);
      e_pa = '0;
      check(rsp_pte == e_pte, "R5", rsp_pte, e_pte);
      check(rsp_paddr == e_pa, "R5", rsp_paddr, e_pa);
    end else begin
      check(rd_n == 2, "R3", rd_n, 2);
      check(rd_addr1 == {LEAF_BASE + {10'd0, mi}, si, 2'b00}, "R3", rd_addr1,
            {LEAF_BASE + {10'd0, mi}, si, 2'b00});
      e_pte = leaf_entry(mi, si);
      if (lv) begin
        e_pa = {({mi, si} ^ 20'hA5A5A), off};
        check(!rsp_fault, "R4", {31'd0, rsp_fault}, 32'd0);
        check(rsp_pte == e_pte, "R4", rsp_pte, e_pte);
        check(rsp_paddr == e_pa, "R4", rsp_paddr, e_pa);
      end else begin
        check(rsp_fault && rsp_level, "R6", {30'd0, rsp_fault, rsp_level}, 32'd3);
        check(rsp_pte == e_pte, "R6", rsp_pte, e_pte);
        check(rsp_paddr == 32'd0, "R6", rsp_paddr, 32'd0);
      end
    end
    if (mode == 3) begin
      s_pte = rsp_pte; s_pa = rsp_paddr; s_va = rsp_vaddr; s_f = rsp_fault; s_l = rsp_level;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(rsp_valid && rsp_pte == s_pte && rsp_paddr == s_pa && rsp_vaddr == s_va &&
              rsp_fault == s_f && rsp_level == s_l, "R8", rsp_paddr, s_pa);
        check(req_ready == 1'b0, "R7", {31'd0, req_ready}, 32'd0);
      end
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R7", {30'd0, rsp_valid, req_ready}, 32'd1);
    root_frame = ROOT;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", {31'd0, req_ready}, 32'd1);
    check(mem_req == 1'b0, "R1", {31'd0, mem_req}, 32'd0);
    check(rsp_valid == 1'b0, "R1", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req && !rsp_valid, "R1", {29'd0, req_ready, mem_req, rsp_valid}, 32'd4);
    for (int i = 0; i < 1024; i++) begin
      logic [9:0] si = 10'((i * 37 + 5) % 1024);
      logic [11:0] off = 12'((i * 13) % 4096);
      walk({i[9:0], si, off}, i % 3, i % 4);
    end
    for (int i = 0; i < 1024; i++) begin
      logic [9:0] mi = 10'((i * 11) % 1024);
      logic [11:0] off = 12'(4095 - ((i * 7) % 4096));
      walk({mi, i[9:0], off}, (i + 1) % 3, (i + 2) % 4);
    end
    finish_run();
  end
endmodule